// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves bytes between memory and peripherals without the processor's help. Each of four channels has a start address, a transfer count and a direction. While the processor owns the bus, it programs these registers one byte at a time through a small register window. When an enabled channel raises its request line, the controller asks for the bus with a hold request. Once hold acknowledge comes back, it grants one channel at a time. Each grant drives the memory address together with the matching pair of memory and I/O strobes.

Every transfer occupies a fixed four-clock cycle, and a ready input can stretch that cycle. After each transfer the channel's address steps up and its count steps down. On the channel's last transfer the controller pulses terminal count, records the event in a status register that clears when read, and disables the channel. The processor picks either a fixed order, where the lowest channel number wins, or a rotating order, where the channel just served drops to the back.

There is no data path through the block, so no interface needs back-pressure. The request, acknowledge and strobe pins are plain level signals. The ready pin is the only way to stall a transfer.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the enables, the rotate flag, the status, and every address and count register read as zero. Reset also drops hold_req, dack, all strobes and tc.
- R2: Register window. cpu_addr 0 to 7 select channel cpu_addr[2:1]; cpu_addr[0]=0 is its address register and 1 is its count register. Each access to this range moves a shared byte pointer that alternates low byte, then high byte. Reset and a write to cpu_addr 8 return the pointer to the low byte. A write to cpu_addr 8 loads the mode and a read returns the status. Every other address reads 0.
- R3: Mode bits [3:0] enable channels 0 to 3 and bit 4 selects rotating priority. A request on a disabled channel is ignored: hold_req stays low and no dack is given.
- R4: hold_req rises when any enabled channel requests. No dack is given until hold_ack is high. hold_req falls once no enabled request remains.
- R5: A transfer lasts four clocks. dack and dma_addr stay valid in all four clocks, and the strobes are active in the second and third. Back-to-back transfers start four clocks apart.
- R6: Count bit 15 set makes a read transfer (mem_rd with io_wr). Bit 15 clear makes a write transfer (io_rd with mem_wr).
- R7: ready is sampled in the third clock. While it is low, the strobes stay active and the cycle does not advance.
- R8: After each transfer the channel's address rises by 1 and the low 14 bits of its count fall by 1, wrapping. Count bits 15:14 are kept.
- R9: A loaded count N gives N+1 transfers. tc is high in the fourth clock of the last transfer, and that channel's enable bit is then cleared.
- R10: Status bit n is set when channel n reaches terminal count. A status read returns the bits and clears them after the read.
- R11: In fixed priority the lowest-numbered requesting channel wins each arbitration.
- R12: In rotating priority the channel just served becomes the lowest priority for the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Register window select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte |
| dreq | input | 4 | Channel requests |
| dack | output | 4 | One-hot channel grant |
| hold_req | output | 1 | Bus request to processor |
| hold_ack | input | 1 | Bus granted by processor |
| ready | input | 1 | Low inserts wait clocks |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| dma_addr | output | 16 | Memory address of the current transfer |
| tc | output | 1 | Terminal count pulse |

## Verification
Some internal faults show up at once. A corrupted address or count register is visible in the next transfer's dma_addr, in the position of the tc pulse within a burst, and in the values read back after the burst. A wrong priority pointer changes the order of channels in dack on the very next arbitration. Other faults need a wait before they show. If an enable bit is not cleared at terminal count, or the hold state is stuck, hold_req stays high past the last transfer, and this is visible within one clock of the final fourth phase. A broken phase counter shows as strobe runs or cycle spacings other than two and four clocks.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH     = 4;
  localparam int CHW     = $clog2(NCH);
  localparam int DW      = 8;
  localparam int AW      = 2 * DW;
  localparam int CW      = 14;
  localparam int RAW     = 4;
  localparam int DIR_BIT = AW - 1;
  localparam logic [RAW-1:0] MODE_ADDR = RAW'(8);

  typedef enum logic [2:0] {PH_IDLE, PH_ONE, PH_TWO, PH_THREE, PH_FOUR} phase_t;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_sel,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic [RAW-1:0]          cpu_addr,
  input  logic [DW-1:0]           cpu_wdata,
  output logic [DW-1:0]           cpu_rdata,
  input  logic                    upd,
  input  logic [CHW-1:0]          upd_ch,
  output logic [NCH-1:0][AW-1:0]  addr_q,
  output logic [NCH-1:0][AW-1:0]  cnt_q,
  output logic [NCH-1:0]          en_q,
  output logic                    rot_q
);
  logic [NCH-1:0] stat_q;
  logic           ptr_hi;
  logic [AW-1:0]  word;

  wire            win     = ~cpu_addr[RAW-1];
  wire            ch_acc  = cpu_sel & (cpu_wr | cpu_rd) & win;
  wire            ch_wr   = cpu_sel & cpu_wr & win;
  wire            mode_wr = cpu_sel & cpu_wr & (cpu_addr == MODE_ADDR);
  wire            stat_rd = cpu_sel & cpu_rd & (cpu_addr == MODE_ADDR);
  wire [CHW-1:0]  sel_ch  = cpu_addr[CHW:1];
  wire            upd_tc  = upd & (cnt_q[upd_ch][CW-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= '0;
      rot_q  <= 1'b0;
      stat_q <= '0;
      ptr_hi <= 1'b0;
    end else begin
      if (ch_acc) ptr_hi <= ~ptr_hi;
      if (ch_wr) begin
        if (cpu_addr[0]) begin
          if (ptr_hi) cnt_q[sel_ch][AW-1:DW] <= cpu_wdata;
          else        cnt_q[sel_ch][DW-1:0]  <= cpu_wdata;
        end else begin
          if (ptr_hi) addr_q[sel_ch][AW-1:DW] <= cpu_wdata;
          else        addr_q[sel_ch][DW-1:0]  <= cpu_wdata;
        end
      end
      if (mode_wr) begin
        ptr_hi <= 1'b0;
        en_q   <= cpu_wdata[NCH-1:0];
        rot_q  <= cpu_wdata[NCH];
      end
      if (stat_rd) stat_q <= '0;
      if (upd) begin
        addr_q[upd_ch]          <= addr_q[upd_ch] + 1'b1;
        cnt_q[upd_ch][CW-1:0]   <= cnt_q[upd_ch][CW-1:0] - 1'b1;
        if (upd_tc) begin
          stat_q[upd_ch] <= 1'b1;
          en_q[upd_ch]   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    word      = cpu_addr[0] ? cnt_q[sel_ch] : addr_q[sel_ch];
    if (win)
      cpu_rdata = ptr_hi ? word[AW-1:DW] : word[DW-1:0];
    else if (cpu_addr == MODE_ADDR)
      cpu_rdata = {{(DW-NCH){1'b0}}, stat_q};
  end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
  import dma4_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic           rot,
  input  logic [CHW-1:0] last,
  output logic           gnt_v,
  output logic [CHW-1:0] gnt_idx
);
  logic [CHW-1:0] base;
  logic [CHW-1:0] idx;

  always_comb begin
    base    = rot ? last : CHW'(NCH - 1);
    gnt_v   = 1'b0;
    gnt_idx = '0;
    idx     = '0;
    for (int i = 1; i <= NCH; i++) begin
      idx = CHW'((int'(base) + i) % NCH);
      if (!gnt_v && req[idx]) begin
        gnt_v   = 1'b1;
        gnt_idx = idx;
      end
    end
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] en,
  input  logic           rot,
  input  logic           cnt_zero,
  input  logic           ready,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [NCH-1:0] dack,
  output logic           strobe_on,
  output logic           busy,
  output logic           upd,
  output logic           tc,
  output logic [CHW-1:0] cur_ch
);
  phase_t         ph;
  logic [CHW-1:0] rr_q;
  logic [NCH-1:0] en_eff;
  logic [CHW-1:0] last_eff;
  logic           gnt_v;
  logic [CHW-1:0] gnt_idx;

  wire in_four = (ph == PH_FOUR);

  always_comb begin
    en_eff   = en;
    last_eff = rr_q;
    if (in_four) begin
      last_eff = cur_ch;
      if (cnt_zero) en_eff[cur_ch] = 1'b0;
    end
  end

  dma4_arb i_arb (
    .req     (dreq & en_eff),
    .rot     (rot),
    .last    (last_eff),
    .gnt_v   (gnt_v),
    .gnt_idx (gnt_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      rr_q     <= CHW'(NCH - 1);
      cur_ch   <= '0;
      hold_req <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          hold_req <= gnt_v;
          if (hold_req && hold_ack && gnt_v) begin
            ph     <= PH_ONE;
            cur_ch <= gnt_idx;
          end
        end
        PH_ONE:   ph <= PH_TWO;
        PH_TWO:   ph <= PH_THREE;
        PH_THREE: if (ready) ph <= PH_FOUR;
        PH_FOUR: begin
          rr_q     <= cur_ch;
          hold_req <= gnt_v;
          if (gnt_v && hold_ack) begin
            ph     <= PH_ONE;
            cur_ch <= gnt_idx;
          end else begin
            ph <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (ph != PH_IDLE);
  assign dack      = busy ? (NCH'(1) << cur_ch) : '0;
  assign strobe_on = (ph == PH_TWO) || (ph == PH_THREE);
  assign upd       = in_four;
  assign tc        = in_four && cnt_zero;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_sel,
  input  logic           cpu_wr,
  input  logic           cpu_rd,
  input  logic [RAW-1:0] cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           ready,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic [AW-1:0]  dma_addr,
  output logic           tc
);
  logic [NCH-1:0][AW-1:0] addr_q;
  logic [NCH-1:0][AW-1:0] cnt_q;
  logic [NCH-1:0]         en_q;
  logic                   rot_q;
  logic                   upd;
  logic                   strobe_on;
  logic                   busy;
  logic [CHW-1:0]         cur_ch;

  wire [AW-1:0] cur_cnt  = cnt_q[cur_ch];
  wire          cnt_zero = (cur_cnt[CW-1:0] == '0);
  wire          dir_rd   = cur_cnt[DIR_BIT];

  dma4_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .upd       (upd),
    .upd_ch    (cur_ch),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .en_q      (en_q),
    .rot_q     (rot_q)
  );

  dma4_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq      (dreq),
    .en        (en_q),
    .rot       (rot_q),
    .cnt_zero  (cnt_zero),
    .ready     (ready),
    .hold_ack  (hold_ack),
    .hold_req  (hold_req),
    .dack      (dack),
    .strobe_on (strobe_on),
    .busy      (busy),
    .upd       (upd),
    .tc        (tc),
    .cur_ch    (cur_ch)
  );

  assign mem_rd   = strobe_on &  dir_rd;
  assign io_wr    = strobe_on &  dir_rd;
  assign io_rd    = strobe_on & ~dir_rd;
  assign mem_wr   = strobe_on & ~dir_rd;
  assign dma_addr = busy ? addr_q[cur_ch] : '0;
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk
  import dma4_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           ready,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic [AW-1:0]  dma_addr,
  input logic           tc
);
  wire strobe = mem_rd | io_rd;

  // R6
  dir_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == io_wr) && (io_rd == mem_wr) && !(mem_rd && io_rd));

  // R5
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R5
  strobe_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (dack != '0));

  // R4
  grant_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dack) |-> $past(hold_ack));

  // R4
  hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> hold_req);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ready) |=> strobe);

  // R9
  tc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ((dack != '0) && !strobe));

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ($past(dack) != '0)) |-> $stable(dma_addr));
endmodule

bind dma4_ctrl dma4_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dack     (dack),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .ready    (ready),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .io_rd    (io_rd),
  .io_wr    (io_wr),
  .dma_addr (dma_addr),
  .tc       (tc)
);

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [3:0] dreq = '0;
  logic [3:0] dack;
  logic       hold_req, hold_ack;
  logic       ack_en = 1'b1;
  logic       ready = 1'b1;
  logic       mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] dma_addr;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_log = 0;
  int base = 0;
  int log_ch [LOGN];
  int log_addr [LOGN];
  int log_tc [LOGN];
  int log_rd [LOGN];
  int log_len [LOGN];
  int log_cyc [LOGN];
  int scnt = 0;
  logic prev_strobe = 1'b0;
  logic prev_memrd = 1'b0;

  assign hold_ack = hold_req & ack_en;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma4_ctrl i_dma4_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack), .ready(ready),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .dma_addr(dma_addr), .tc(tc)
  );

  // transfer monitor: logs each transfer in its fourth clock
  always @(negedge clk) begin
    logic strobe;
    strobe = mem_rd | mem_wr | io_rd | io_wr;
    if (!rst_n) begin
      scnt = 0;
      prev_strobe = 1'b0;
    end else begin
      if (strobe) scnt = scnt + 1;
      if (!strobe && prev_strobe && dack != 4'b0 && n_log < LOGN) begin
        for (int k = 0; k < 4; k++) if (dack[k]) log_ch[n_log] = k;
        log_addr[n_log] = int'(dma_addr);
        log_tc[n_log]   = int'(tc);
        log_rd[n_log]   = int'(prev_memrd);
        log_len[n_log]  = scnt;
        log_cyc[n_log]  = cyc;
        n_log = n_log + 1;
        scnt = 0;
      end
      prev_strobe = strobe;
      prev_memrd  = mem_rd;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dreq = '0; ready = 1'b1; ack_en = 1'b1;
    cpu_sel = 0; cpu_wr = 0; cpu_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    base = n_log;
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [7:0] d);
    cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
    #(CLK_PERIOD/4);
    d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0;
  endtask

  task automatic prog_ch(input int ch, input logic [15:0] a, input logic [15:0] c);
    cpu_write(4'(ch*2), a[7:0]);   cpu_write(4'(ch*2), a[15:8]);
    cpu_write(4'(ch*2+1), c[7:0]); cpu_write(4'(ch*2+1), c[15:8]);
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 400 && n_log < base + n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    check("R1", "hold_req", int'(hold_req), 0);
    check("R1", "dack", int'(dack), 0);
    check("R1", "strobes", int'({mem_rd, mem_wr, io_rd, io_wr, tc}), 0);
    cpu_read(4'h8, d); check("R1", "status", int'(d), 0);
    cpu_read(4'h2, d); check("R1", "ch1 addr lo", int'(d), 0);
    cpu_read(4'h2, d); check("R1", "ch1 addr hi", int'(d), 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_reset();
    cpu_write(4'h4, 8'hEF); cpu_write(4'h4, 8'hBE);
    cpu_write(4'h5, 8'h34); cpu_write(4'h5, 8'h12);
    cpu_read(4'h4, d); check("R2", "ch2 addr lo", int'(d), 'hEF);
    cpu_read(4'h4, d); check("R2", "ch2 addr hi", int'(d), 'hBE);
    cpu_read(4'h5, d); check("R2", "ch2 cnt lo", int'(d), 'h34);
    cpu_read(4'h5, d); check("R2", "ch2 cnt hi", int'(d), 'h12);
    cpu_write(4'h6, 8'h55);
    cpu_write(4'h8, 8'h00);
    cpu_write(4'h6, 8'hAA); cpu_write(4'h6, 8'h77);
    cpu_read(4'h6, d); check("R2", "ptr restart lo", int'(d), 'hAA);
    cpu_read(4'h6, d); check("R2", "ptr restart hi", int'(d), 'h77);
    cpu_read(4'hF, d); check("R2", "unused addr", int'(d), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    prog_ch(1, 16'h0100, 16'h0001);
    cpu_write(4'h8, 8'h0D);
    dreq = 4'b0010;
    repeat (10) @(negedge clk);
    check("R3", "hold_req disabled ch", int'(hold_req), 0);
    check("R3", "no transfer", n_log - base, 0);
    dreq = '0;
  endtask

  task automatic t_hold_wait();
    do_reset();
    ack_en = 1'b0;
    prog_ch(2, 16'h0200, 16'h0000);
    cpu_write(4'h8, 8'h04);
    dreq = 4'b0100;
    repeat (6) @(negedge clk);
    check("R4", "hold_req raised", int'(hold_req), 1);
    check("R4", "no dack before ack", int'(dack), 0);
    check("R4", "no transfer before ack", n_log - base, 0);
    ack_en = 1'b1;
    wait_log(1);
    repeat (3) @(negedge clk);
    check("R4", "hold_req drops", int'(hold_req), 0);
    check("R9", "single tc", log_tc[base], 1);
    check("R6", "write direction", log_rd[base], 0);
    check("R5", "addr", log_addr[base], 'h0200);
    dreq = '0;
  endtask

  task automatic t_burst_read();
    logic [7:0] d;
    do_reset();
    prog_ch(0, 16'h1000, 16'h8002);
    cpu_write(4'h8, 8'h01);
    dreq = 4'b0001;
    wait_log(3);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R8", "burst addr", log_addr[base+i], 'h1000 + i);
      check("R9", "tc position", log_tc[base+i], (i == 2) ? 1 : 0);
      check("R6", "read direction", log_rd[base+i], 1);
      check("R5", "strobe length", log_len[base+i], 2);
    end
    check("R5", "spacing 1", log_cyc[base+1] - log_cyc[base], 4);
    check("R5", "spacing 2", log_cyc[base+2] - log_cyc[base+1], 4);
    check("R9", "count N+1 then stop", n_log - base, 3);
    check("R9", "hold_req off after tc", int'(hold_req), 0);
    cpu_read(4'h8, d); check("R10", "status set", int'(d), 'h01);
    cpu_read(4'h8, d); check("R10", "status cleared", int'(d), 0);
    cpu_read(4'h0, d); check("R8", "addr lo", int'(d), 'h03);
    cpu_read(4'h0, d); check("R8", "addr hi", int'(d), 'h10);
    cpu_read(4'h1, d); check("R8", "cnt lo", int'(d), 'hFF);
    cpu_read(4'h1, d); check("R8", "cnt hi keeps bit15", int'(d), 'hBF);
    dreq = '0;
  endtask

  task automatic t_ready();
    do_reset();
    ready = 1'b0;
    prog_ch(3, 16'h0030, 16'h0000);
    cpu_write(4'h8, 8'h08);
    dreq = 4'b1000;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (io_rd) break;
    end
    repeat (5) @(negedge clk);
    ready = 1'b1;
    wait_log(1);
    check("R7", "stretched strobe", log_len[base], 6);
    check("R6", "write direction mem_wr", log_rd[base], 0);
    check("R7", "addr", log_addr[base], 'h0030);
    dreq = '0;
  endtask

  task automatic t_fixed();
    logic [7:0] d;
    do_reset();
    prog_ch(1, 16'h0100, 16'h8001);
    prog_ch(3, 16'h0300, 16'h8001);
    cpu_write(4'h8, 8'h0A);
    dreq = 4'b1010;
    wait_log(4);
    check("R11", "order 0", log_ch[base], 1);
    check("R11", "order 1", log_ch[base+1], 1);
    check("R11", "order 2", log_ch[base+2], 3);
    check("R11", "order 3", log_ch[base+3], 3);
    check("R11", "addr 2", log_addr[base+2], 'h0300);
    repeat (3) @(negedge clk);
    cpu_read(4'h8, d); check("R10", "status two channels", int'(d), 'h0A);
    dreq = '0;
  endtask

  task automatic t_rotate();
    do_reset();
    prog_ch(0, 16'h0000, 16'h8001);
    prog_ch(2, 16'h0020, 16'h8001);
    cpu_write(4'h8, 8'h15);
    dreq = 4'b0101;
    wait_log(4);
    check("R12", "order 0", log_ch[base], 0);
    check("R12", "order 1", log_ch[base+1], 2);
    check("R12", "order 2", log_ch[base+2], 0);
    check("R12", "order 3", log_ch[base+3], 2);
    check("R12", "addr 3", log_addr[base+3], 'h0021);
    dreq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_regs();
    t_disabled();
    t_hold_wait();
    t_burst_read();
    t_ready();
    t_fixed();
    t_rotate();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule